// File: doc/BRIEF.md
# UART Receive Character Buffer

This block sits between the deserializer of a memory-mapped serial port and its data register. Each byte the deserializer delivers is stored in a circular buffer. The buffer is addressed by a head pointer and an occupancy count. A read strobe on the data register pops the oldest entry. The block keeps the empty and full status flags and a level-based receive interrupt request. It also reports how many slots are free, so the byte source can throttle itself.

A mode bit selects character mode or FIFO mode, and the two modes set the full flag differently. Any change of the mode bit discards the buffered bytes. A write to either the mode register or the level-select register returns the interrupt trigger level to one. A byte that arrives while every slot is taken is discarded, and the block reports this with a one-cycle overflow pulse.

Top module: `uart_rx_buffer`

## Requirements
- R1: After synchronous reset, empty_flag is 1, full_flag is 0, rx_irq is 0, overflow is 0 and free_space is 16.
- R2: Bytes leave in arrival order. head_data shows the oldest stored byte, including after the head and write positions wrap from slot 15 back to slot 0.
- R3: free_space always equals 16 minus the number of stored bytes. An accepted byte lowers it by one and a pop of a non-empty buffer raises it by one.
- R4: With cfg_mode_val = 0 (character mode), every accepted byte sets full_flag. With cfg_mode_val = 1 (FIFO mode), an accepted byte sets full_flag only when it brings the count to 16.
- R5: Every pop clears full_flag.
- R6: An accepted byte clears empty_flag. A pop that leaves the count at zero sets it.
- R7: rx_irq is set when an accepted byte brings the count to at least the trigger level, which is 1 after reset and after any configuration write. rx_irq is cleared when a pop leaves the count at trigger minus one.
- R8: A pop while the count is zero leaves the count and head_data unchanged. It still clears full_flag and sets empty_flag.
- R9: A mode write whose value differs from the current mode empties the buffer (free_space returns to 16) without touching empty_flag or rx_irq, and the next byte appears at head_data. A mode write with an unchanged value, and a level-select write, leave the contents alone.
- R10: A byte that arrives while the count is 16 and no pop is present is dropped. The count and the contents stay unchanged, and overflow pulses high for exactly one cycle.
- R11: When a byte and a pop arrive in the same cycle, the pop is applied first. The count is unchanged, and at 16 the new byte is accepted with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_byte | input | 8 | Received byte |
| pop | input | 1 | Data-register read strobe, removes the head entry |
| cfg_wr_mode | input | 1 | Write strobe of the mode bit |
| cfg_mode_val | input | 1 | Mode value written: 0 character mode, 1 FIFO mode |
| cfg_wr_level | input | 1 | Write strobe of the level-select register |
| head_data | output | 8 | Oldest stored byte |
| full_flag | output | 1 | Receive-full status |
| empty_flag | output | 1 | Receive-empty status |
| free_space | output | 5 | Free slots, 16 minus the count |
| rx_irq | output | 1 | Receive-level interrupt request |
| overflow | output | 1 | One-cycle pulse on a dropped byte |

## Verification
The bench fills the buffer to exactly 16 in FIFO mode and then offers a seventeenth byte. A design that wraps the write slot without checking the count would overwrite the oldest byte, and the drained order would show it. The bench runs a full drain-and-refill so that both positions cross slot 15. A wrong modulo would return a stale byte. It issues pops on an empty buffer, which a naive counter would underflow into a free_space of 17 or more. It issues a simultaneous push and pop at 16, which a push-first ordering would turn into a false overflow. It also writes the mode with an unchanged and then a changed value; a design that flushes on every write, or that clears the flags on a flush, would show a wrong free_space or wrong flags.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;

    localparam int unsigned RXB_DEPTH  = 16;
    localparam int unsigned RXB_DATA_W = 8;

    typedef enum logic {
        MODE_CHAR = 1'b0,
        MODE_FIFO = 1'b1
    } rxb_mode_e;

    typedef struct packed {
        logic full;
        logic empty;
        logic irq;
    } rxb_flags_t;

    localparam rxb_flags_t RXB_FLAGS_RESET = '{full: 1'b0, empty: 1'b1, irq: 1'b0};

endpackage

// File: rtl/rxb_storage.sv
module rxb_storage #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PTR_W-1:0]  wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  hit;

    // one-hot write decode, one lane per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_dec
        assign hit[g] = we && (wr_slot == PTR_W'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (hit[i]) begin
                mem[i] <= wr_data;
            end
        end
    end

    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/rxb_occupancy.sv
module rxb_occupancy #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             pop,
    input  logic             push,
    output logic [PTR_W-1:0] ptr_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_p,
    output logic [CNT_W-1:0] cnt_n,
    output logic [PTR_W-1:0] wr_slot,
    output logic             accept,
    output logic             drop
);

    localparam int unsigned SUM_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [SUM_W-1:0] DEPTH_S  = SUM_W'(DEPTH);

    logic [CNT_W-1:0] cnt_f;
    logic [PTR_W-1:0] ptr_f, ptr_p;
    logic             pop_eff;
    logic [SUM_W-1:0] sum_raw, sum_wrap;

    // order inside a cycle: flush, then pop, then push
    always_comb begin
        cnt_f   = flush ? '0 : cnt_q;
        ptr_f   = flush ? '0 : ptr_q;
        pop_eff = pop && (cnt_f != '0);
        cnt_p   = pop_eff ? cnt_f - 1'b1 : cnt_f;
        if (pop_eff) begin
            ptr_p = (ptr_f == LAST_PTR) ? '0 : ptr_f + 1'b1;
        end else begin
            ptr_p = ptr_f;
        end
        accept   = push && (cnt_p != DEPTH_C);
        drop     = push && !accept;
        sum_raw  = SUM_W'(ptr_p) + SUM_W'(cnt_p);
        sum_wrap = (sum_raw >= DEPTH_S) ? sum_raw - DEPTH_S : sum_raw;
        wr_slot  = sum_wrap[PTR_W-1:0];
        cnt_n    = cnt_p + CNT_W'(accept);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else begin
            ptr_q <= ptr_p;
            cnt_q <= cnt_n;
        end
    end

endmodule

// File: rtl/rxb_status.sv
module rxb_status
    import uart_rxb_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    input  logic             accept,
    input  logic             drop,
    input  logic             cfg_touch,
    input  logic             fifo_mode,
    input  logic [CNT_W-1:0] cnt_p,
    input  logic [CNT_W-1:0] cnt_n,
    output rxb_flags_t       flags_q,
    output logic             ovf_q
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] TRIG_RST = CNT_W'(1);

    logic [CNT_W-1:0] trig_q, trig_e, trig_m1;
    rxb_flags_t       flags_d;

    always_comb begin
        trig_e  = cfg_touch ? TRIG_RST : trig_q;
        trig_m1 = trig_e - 1'b1;
        flags_d = flags_q;
        if (pop) begin
            flags_d.full = 1'b0;
            if (cnt_p == '0) begin
                flags_d.empty = 1'b1;
            end
            if (cnt_p == trig_m1) begin
                flags_d.irq = 1'b0;
            end
        end
        if (accept) begin
            flags_d.empty = 1'b0;
            if (!fifo_mode || (cnt_n == DEPTH_C)) begin
                flags_d.full = 1'b1;
            end
            if (cnt_n >= trig_e) begin
                flags_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q  <= TRIG_RST;
            flags_q <= RXB_FLAGS_RESET;
            ovf_q   <= 1'b0;
        end else begin
            trig_q  <= trig_e;
            flags_q <= flags_d;
            ovf_q   <= drop;
        end
    end

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rxb_pkg::*;
#(
    parameter int unsigned DEPTH  = RXB_DEPTH,
    parameter int unsigned DATA_W = RXB_DATA_W,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              pop,
    input  logic              cfg_wr_mode,
    input  logic              cfg_mode_val,
    input  logic              cfg_wr_level,
    output logic [DATA_W-1:0] head_data,
    output logic              full_flag,
    output logic              empty_flag,
    output logic [CNT_W-1:0]  free_space,
    output logic              rx_irq,
    output logic              overflow
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    rxb_mode_e        mode_q;
    logic             flush, fifo_mode, cfg_touch;
    logic [PTR_W-1:0] ptr_q, wr_slot;
    logic [CNT_W-1:0] cnt_q, cnt_p, cnt_n;
    logic             accept, drop;
    rxb_flags_t       flags;

    assign flush     = cfg_wr_mode && (rxb_mode_e'(cfg_mode_val) != mode_q);
    assign fifo_mode = cfg_wr_mode ? cfg_mode_val : (mode_q == MODE_FIFO);
    assign cfg_touch = cfg_wr_mode || cfg_wr_level;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_CHAR;
        end else if (cfg_wr_mode) begin
            mode_q <= rxb_mode_e'(cfg_mode_val);
        end
    end

    rxb_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .pop     (pop),
        .push    (in_valid),
        .ptr_q   (ptr_q),
        .cnt_q   (cnt_q),
        .cnt_p   (cnt_p),
        .cnt_n   (cnt_n),
        .wr_slot (wr_slot),
        .accept  (accept),
        .drop    (drop)
    );

    rxb_storage #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .we      (accept),
        .wr_slot (wr_slot),
        .wr_data (in_byte),
        .rd_ptr  (ptr_q),
        .rd_data (head_data)
    );

    rxb_status #(.DEPTH(DEPTH)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .pop       (pop),
        .accept    (accept),
        .drop      (drop),
        .cfg_touch (cfg_touch),
        .fifo_mode (fifo_mode),
        .cnt_p     (cnt_p),
        .cnt_n     (cnt_n),
        .flags_q   (flags),
        .ovf_q     (overflow)
    );

    assign full_flag  = flags.full;
    assign empty_flag = flags.empty;
    assign rx_irq     = flags.irq;
    assign free_space = DEPTH_C - cnt_q;

endmodule

// File: rtl/uart_rx_buffer_chk.sv
module uart_rx_buffer_chk #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             pop,
    input logic             cfg_wr_mode,
    input logic             full_flag,
    input logic             empty_flag,
    input logic [CNT_W-1:0] free_space,
    input logic             rx_irq,
    input logic             overflow
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (empty_flag && !full_flag && !rx_irq && free_space == DEPTH_C));

    assert_free_bound_R3: assert property (@(posedge clk) disable iff (rst)
        free_space <= DEPTH_C);

    assert_free_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !pop && !cfg_wr_mode) |=> $stable(free_space));

    assert_pop_clears_full_R5: assert property (@(posedge clk) disable iff (rst)
        (pop && !in_valid) |=> !full_flag);

    assert_push_clears_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cfg_wr_mode && (free_space != '0 || pop)) |=> !empty_flag);

    assert_push_raises_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cfg_wr_mode && (free_space != '0 || pop)) |=> rx_irq);

    assert_no_false_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        overflow |-> $past(in_valid && !pop && free_space == '0));

    assert_overflow_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        (overflow && !($past(in_valid) && $past(free_space) == '0)) |-> 1'b0);

endmodule

bind uart_rx_buffer uart_rx_buffer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .pop         (pop),
    .cfg_wr_mode (cfg_wr_mode),
    .full_flag   (full_flag),
    .empty_flag  (empty_flag),
    .free_space  (free_space),
    .rx_irq      (rx_irq),
    .overflow    (overflow)
);

// File: tb/uart_rx_buffer_test.sv
module uart_rx_buffer_test;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       pop = 1'b0;
    logic       cfg_wr_mode = 1'b0;
    logic       cfg_mode_val = 1'b0;
    logic       cfg_wr_level = 1'b0;
    logic [7:0] head_data;
    logic       full_flag, empty_flag, rx_irq, overflow;
    logic [4:0] free_space;

    int errors = 0;
    int checks = 0;
    logic [7:0] sb[$];

    always #5 clk = ~clk;

    uart_rx_buffer uut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .pop          (pop),
        .cfg_wr_mode  (cfg_wr_mode),
        .cfg_mode_val (cfg_mode_val),
        .cfg_wr_level (cfg_wr_level),
        .head_data    (head_data),
        .full_flag    (full_flag),
        .empty_flag   (empty_flag),
        .free_space   (free_space),
        .rx_irq       (rx_irq),
        .overflow     (overflow)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_free(string tag);
        chk(tag, int'(free_space), DEPTH - sb.size());
    endtask

    // one active cycle; returns at the next falling edge with outputs settled
    task automatic cyc(bit v, logic [7:0] b, bit p, bit wm, bit mv, bit wl);
        @(negedge clk);
        in_valid = v; in_byte = b; pop = p;
        cfg_wr_mode = wm; cfg_mode_val = mv; cfg_wr_level = wl;
        @(negedge clk);
        in_valid = 0; pop = 0; cfg_wr_mode = 0; cfg_wr_level = 0;
    endtask

    // driver: records what the buffer must keep
    task automatic drive_byte(logic [7:0] b);
        if (sb.size() < DEPTH) sb.push_back(b);
        cyc(1, b, 0, 0, 0, 0);
    endtask

    // monitor: head must match the oldest expected byte, then pop it
    task automatic take(string tag);
        if (sb.size() > 0) begin
            chk(tag, int'(head_data), int'(sb[0]));
            void'(sb.pop_front());
        end
        cyc(0, 8'h00, 1, 0, 0, 0);
    endtask

    task automatic take_and_give(string tag, logic [7:0] b);
        chk(tag, int'(head_data), int'(sb[0]));
        void'(sb.pop_front());
        sb.push_back(b);
        cyc(1, b, 1, 0, 0, 0);
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] h;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 empty", empty_flag, 1);
        chk("R1 full", full_flag, 0);
        chk("R1 irq", rx_irq, 0);
        chk("R1 overflow", overflow, 0);
        chk_free("R1 free");

        // character mode
        drive_byte(8'h12);
        chk("R4 char full", full_flag, 1);
        chk("R6 empty cleared", empty_flag, 0);
        chk("R7 irq set", rx_irq, 1);
        chk_free("R3 free after push");
        drive_byte(8'h34);
        chk_free("R3 free after 2");
        take("R2 head 1st");
        chk("R5 pop clears full", full_flag, 0);
        chk("R7 irq held count1", rx_irq, 1);
        chk_free("R3 free after pop");
        take("R2 head 2nd");
        chk("R6 empty set", empty_flag, 1);
        chk("R7 irq cleared", rx_irq, 0);

        // R8 pop of an empty buffer
        h = head_data;
        cyc(0, 8'h00, 1, 0, 0, 0);
        chk("R8 head stable", int'(head_data), int'(h));
        chk("R8 empty", empty_flag, 1);
        chk_free("R8 free");

        // FIFO mode, fill to 16
        cyc(0, 8'h00, 0, 1, 1, 0);
        chk_free("R9 flush on switch");
        for (int i = 0; i < DEPTH - 1; i++) drive_byte(8'h40 + 8'(i));
        chk("R4 fifo not full at 15", full_flag, 0);
        drive_byte(8'h4F);
        chk("R4 fifo full at 16", full_flag, 1);
        chk_free("R3 free at 16");
        drive_byte(8'hEE);
        chk("R10 overflow pulse", overflow, 1);
        chk_free("R10 count held");
        cyc(0, 8'h00, 0, 0, 0, 0);
        chk("R10 overflow one cycle", overflow, 0);
        for (int i = 0; i < DEPTH; i++) take("R2/R10 drain order");
        chk("R6 empty after drain", empty_flag, 1);

        // wrap across slot 15
        for (int i = 0; i < 10; i++) drive_byte(8'h80 + 8'(i));
        for (int i = 0; i < 10; i++) take("R2 pre-wrap");
        for (int i = 0; i < 10; i++) drive_byte(8'hA0 + 8'(i));
        chk_free("R3 after wrap fill");
        for (int i = 0; i < 10; i++) take("R2 wrap order");

        // simultaneous push and pop
        drive_byte(8'h01); drive_byte(8'h02); drive_byte(8'h03);
        take_and_give("R11 head", 8'h04);
        chk_free("R11 count kept");
        take_and_give("R11 head 2", 8'h05);
        for (int i = 0; i < 13; i++) drive_byte(8'hC0 + 8'(i));
        chk_free("R11 at 16");
        take_and_give("R11 head at 16", 8'hDD);
        chk("R11 no overflow", overflow, 0);
        chk_free("R11 still 16");
        for (int i = 0; i < 11; i++) take("R2 partial drain");
        chk_free("R3 five left");

        // R9 configuration writes
        cyc(0, 8'h00, 0, 0, 0, 1);
        chk_free("R9 level write keeps data");
        cyc(0, 8'h00, 0, 1, 1, 0);
        chk_free("R9 same mode keeps data");
        chk("R9 head kept", int'(head_data), int'(sb[0]));
        cyc(0, 8'h00, 0, 1, 0, 0);
        sb.delete();
        chk_free("R9 flush on change");
        chk("R9 empty untouched", empty_flag, 0);
        chk("R9 irq untouched", rx_irq, 1);
        drive_byte(8'hA5);
        chk("R9 next byte at head", int'(head_data), 8'hA5);
        chk("R4 char full again", full_flag, 1);
        take("R2 last");
        chk("R6 empty end", empty_flag, 1);
        chk("R7 irq end", rx_irq, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule